// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block supervises software by counting down a programmable timeout. A programmable prescaler divides an always-on safe clock. Each time the prescaler wraps, a period counter advances. If software lets the period counter expire without restarting it, the block raises a reset request toward the chip's reset generator. The two counters run on the safe clock. Software reaches the block through a small register interface on a separate bus clock. Restart and interrupt-clear commands cross into the safe domain through toggle handshakes, so no command is lost.

The control word (enable, debug mode, pause) changes only when the write comes right after an unlock write of the right key. In debug mode an expiry never requests a reset. Instead it sets an interrupt flag, provided the interrupt enable is set, and a write to the clear register removes the flag. When the pause bit is set and the processor's debug-halt input is high, both counters hold their values.

Top module: `wdt_top`

## Requirements
- R1: After reset the control word reads 0, the period register reads 0xFFFFFFFF, and the reset request and interrupt outputs are low.
- R2: With the block enabled, debug mode off and no restarts, the reset request rises every (T+1)*(P+1) safe-clock cycles, where T is the period register (offset 0x08) and P is the prescale register (offset 0x0C).
- R3: Each reset request is high for exactly RST_PULSE (default 4) safe-clock cycles.
- R4: A write to the restart register (offset 0x10) reloads the prescaler to zero and the period counter to T. Restarts that keep arriving faster than the timeout prevent every reset request. Once they stop, a request follows.
- R5: A write to the control register (offset 0x00; bit0 enable, bit1 debug, bit2 pause) takes effect only when the previous bus write went to the key register (offset 0x04) with the value 0x251D8950. A wrong key write or any other write in between relocks the register, and the control word then keeps its value.
- R6: In debug mode an expiry never asserts the reset request. It sets the interrupt output only when bit0 of the interrupt-enable register (offset 0x14) is 1.
- R7: A write of any value to the clear register (offset 0x18) clears a pending interrupt.
- R8: While the pause bit is set and the debug-halt input is high, both counters hold, so the interval between reset requests grows by exactly the number of halted safe cycles. With the pause bit clear, the halt input has no effect.
- R9: While the enable bit is 0, the counters stay at their reload values and no reset request is raised.
- R10: The status register (offset 0x1C) shows the synchronized interrupt flag in bit0, restart-in-flight in bit1 and clear-in-flight in bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| safe_clk | input | 1 | Always-on counter clock |
| safe_rst | input | 1 | Synchronous active-high reset, safe domain |
| dbg_halt_i | input | 1 | Processor halted for debug (asynchronous) |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while a read is selected |
| wdt_rst_req_o | output | 1 | Reset request, safe domain |
| wdt_irq_o | output | 1 | Timeout interrupt, bus domain |

## Verification
The timeout length is measured over a grid of nine prescale and period pairs. Each measured interval is compared with the product formula, which separates an off-by-one in the prescaler from one in the period counter, and the pulse width is checked for each pair. A stream of restarts is contrasted with an abandoned stream to show that restarts reload the count. Halt windows of known length, with the pause bit set and then cleared, show that the pause stretches the interval by exactly those cycles and that the halt input alone does nothing. Correct, wrong and interrupted key sequences tell a working lock from a missing one. Debug runs with the interrupt enable on and off tell the interrupt path apart from the reset path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 5;
    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h251D_8950;

    typedef enum logic [2:0] {
        RG_CTRL   = 3'd0,
        RG_KEY    = 3'd1,
        RG_PERIOD = 3'd2,
        RG_PRESC  = 3'd3,
        RG_KICK   = 3'd4,
        RG_IRQEN  = 3'd5,
        RG_IRQCLR = 3'd6,
        RG_STATUS = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic pause_en;
        logic dbg_mode;
        logic enable;
    } ctrl_t;

    // index of each command channel crossing into the safe domain
    localparam int unsigned XF_KICK = 0;
    localparam int unsigned XF_CLR  = 1;
    localparam int unsigned N_XF    = 2;

    function automatic reg_idx_e addr_to_idx(logic [ADDR_W-1:0] a);
        return reg_idx_e'(a[ADDR_W-1:2]);
    endfunction

    function automatic logic addr_aligned(logic [ADDR_W-1:0] a);
        return a[1:0] == 2'b00;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wdt_xfer.sv
module wdt_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_req_i,
    output logic src_busy_o,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse_o
);
    logic src_tgl, pend_q, ack_s;
    logic tgl_s, tgl_d;

    assign src_busy_o = src_tgl ^ ack_s;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            src_tgl <= 1'b0;
            pend_q  <= 1'b0;
        end else if (!src_busy_o && (src_req_i || pend_q)) begin
            src_tgl <= ~src_tgl;
            pend_q  <= 1'b0;
        end else if (src_req_i) begin
            pend_q  <= 1'b1;
        end
    end

    wdt_sync #(.W(1), .STAGES(STAGES)) u_fwd (
        .clk(dst_clk), .rst(dst_rst), .d_i(src_tgl), .q_o(tgl_s));

    always_ff @(posedge dst_clk) begin
        if (dst_rst) tgl_d <= 1'b0;
        else         tgl_d <= tgl_s;
    end

    assign dst_pulse_o = tgl_s ^ tgl_d;

    wdt_sync #(.W(1), .STAGES(STAGES)) u_ack (
        .clk(src_clk), .rst(src_rst), .d_i(tgl_d), .q_o(ack_s));

    // R4: only one command in flight; a new one waits as pending
    a_r4_one_in_flight: assert property (@(posedge src_clk) disable iff (src_rst)
        src_busy_o |=> $stable(src_tgl));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [BUS_W-1:0]   rdata_o,
    output ctrl_t              ctrl_o,
    output logic [CNT_W-1:0]   period_o,
    output logic [CNT_W-1:0]   presc_o,
    output logic               irq_en_o,
    output logic               kick_o,
    output logic               clr_o,
    input  logic               irq_i,
    input  logic [N_XF-1:0]    busy_i
);
    reg_idx_e idx;
    logic     hit, wr_en, unlock_q;
    ctrl_t    ctrl_q;

    assign idx   = addr_to_idx(addr_i);
    assign hit   = sel_i && addr_aligned(addr_i);
    assign wr_en = hit && wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            unlock_q <= 1'b0;
            period_o <= '1;
            presc_o  <= '0;
            irq_en_o <= 1'b0;
        end else if (wr_en) begin
            unlock_q <= (idx == RG_KEY) && (wdata_i == UNLOCK_KEY);
            case (idx)
                RG_CTRL:   if (unlock_q) ctrl_q <= ctrl_t'(wdata_i[2:0]);
                RG_PERIOD: period_o <= wdata_i[CNT_W-1:0];
                RG_PRESC:  presc_o  <= wdata_i[CNT_W-1:0];
                RG_IRQEN:  irq_en_o <= wdata_i[0];
                default: ;
            endcase
        end
    end

    assign ctrl_o = ctrl_q;
    assign kick_o = wr_en && (idx == RG_KICK);
    assign clr_o  = wr_en && (idx == RG_IRQCLR);

    always_comb begin
        rdata_o = '0;
        if (hit && !wr_i) begin
            case (idx)
                RG_CTRL:   rdata_o = BUS_W'(ctrl_q);
                RG_PERIOD: rdata_o = BUS_W'(period_o);
                RG_PRESC:  rdata_o = BUS_W'(presc_o);
                RG_IRQEN:  rdata_o = BUS_W'(irq_en_o);
                RG_STATUS: rdata_o = BUS_W'({busy_i[XF_CLR], busy_i[XF_KICK], irq_i});
                default:   rdata_o = '0;
            endcase
        end
    end

    // R5: control word changes only right after an unlocking key write
    a_r5_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(unlock_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  logic             halt_i,
    input  logic             irq_en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] presc_i,
    input  logic             kick_i,
    input  logic             clr_i,
    output logic             rst_req_o,
    output logic             irq_o
);
    localparam int PW = $clog2(RST_PULSE + 1);

    logic [CNT_W-1:0] presc_q, cnt_q;
    logic [PW-1:0]    pulse_q;
    logic             hold, wrap, expire;

    assign hold   = ctrl_i.pause_en && halt_i;
    assign wrap   = presc_q == presc_i;
    assign expire = ctrl_i.enable && !kick_i && !hold && wrap && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !ctrl_i.enable || kick_i) begin
            presc_q <= '0;
            cnt_q   <= period_i;
        end else if (!hold) begin
            if (wrap) begin
                presc_q <= '0;
                cnt_q   <= (cnt_q == '0) ? period_i : cnt_q - 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                           pulse_q <= '0;
        else if (expire && !ctrl_i.dbg_mode) pulse_q <= PW'(RST_PULSE);
        else if (pulse_q != '0)            pulse_q <= pulse_q - 1'b1;
    end

    assign rst_req_o = pulse_q != '0;

    always_ff @(posedge clk) begin
        if (rst)                                      irq_o <= 1'b0;
        else if (expire && ctrl_i.dbg_mode && irq_en_i) irq_o <= 1'b1;
        else if (clr_i)                               irq_o <= 1'b0;
    end

    // width of the reset request, counted independently of the stretcher
    logic [15:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst || !rst_req_o) hi_len <= '0;
        else                   hi_len <= hi_len + 1'b1;
    end

    a_r3_min_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req_o) |-> (hi_len >= 16'(RST_PULSE)));
    a_r6_no_rst_in_dbg: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> !$past(ctrl_i.dbg_mode));
    a_r7_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(clr_i));
    a_r8_pause_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.enable && hold && !kick_i) |=> ($stable(cnt_q) && $stable(presc_q)));
    a_r9_idle_reload: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.enable |=> ((presc_q == '0) && (cnt_q == $past(period_i))));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int RST_PULSE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              safe_clk,
    input  logic              safe_rst,
    input  logic              dbg_halt_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              wdt_rst_req_o,
    output logic              wdt_irq_o
);
    ctrl_t            ctrl_b, ctrl_s;
    logic [CNT_W-1:0] period_b, presc_b;
    logic             irq_en_b, irq_en_s, halt_s, irq_s;
    logic [N_XF-1:0]  xf_req, xf_busy, xf_pulse;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(bus_clk), .rst(bus_rst),
        .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
        .ctrl_o(ctrl_b), .period_o(period_b), .presc_o(presc_b),
        .irq_en_o(irq_en_b), .kick_o(xf_req[XF_KICK]), .clr_o(xf_req[XF_CLR]),
        .irq_i(wdt_irq_o), .busy_i(xf_busy));

    for (genvar g = 0; g < N_XF; g++) begin : g_xf
        wdt_xfer #(.STAGES(SYNC_STAGES)) u_xf (
            .src_clk(bus_clk), .src_rst(bus_rst),
            .src_req_i(xf_req[g]), .src_busy_o(xf_busy[g]),
            .dst_clk(safe_clk), .dst_rst(safe_rst), .dst_pulse_o(xf_pulse[g]));
    end

    // level controls and the halt input enter the safe domain
    wdt_sync #(.W(5), .STAGES(SYNC_STAGES)) u_lvl (
        .clk(safe_clk), .rst(safe_rst),
        .d_i({dbg_halt_i, irq_en_b, ctrl_b}),
        .q_o({halt_s, irq_en_s, ctrl_s}));

    wdt_core #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_core (
        .clk(safe_clk), .rst(safe_rst),
        .ctrl_i(ctrl_s), .halt_i(halt_s), .irq_en_i(irq_en_s),
        .period_i(period_b), .presc_i(presc_b),
        .kick_i(xf_pulse[XF_KICK]), .clr_i(xf_pulse[XF_CLR]),
        .rst_req_o(wdt_rst_req_o), .irq_o(irq_s));

    wdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_irq (
        .clk(bus_clk), .rst(bus_rst), .d_i(irq_s), .q_o(wdt_irq_o));
endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    localparam logic [31:0] KEY = 32'h251D_8950;
    localparam logic [31:0] BAD = 32'h1234_5678;

    logic bclk = 1'b0, sclk = 1'b0;
    logic brst, srst, halt, sel, wr;
    logic [4:0]  addr;
    logic [31:0] wdata, rdata;
    logic rst_o, irq_o;

    always #4 bclk = ~bclk;
    always #5 sclk = ~sclk;

    wdt_top u_dut (
        .bus_clk(bclk), .bus_rst(brst), .safe_clk(sclk), .safe_rst(srst),
        .dbg_halt_i(halt), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wdt_rst_req_o(rst_o), .wdt_irq_o(irq_o));

    int checks = 0, errors = 0;
    int scyc = 0, rise_cnt = 0, last_rise = 0, hi_len = 0, last_w = 0;
    logic prev_r = 1'b0;

    // reset request monitor, sampled away from the active edge
    always @(negedge sclk) begin
        scyc <= scyc + 1;
        prev_r <= rst_o;
        if (rst_o && !prev_r) begin
            rise_cnt  <= rise_cnt + 1;
            last_rise <= scyc;
            hi_len    <= 1;
        end else if (rst_o) begin
            hi_len <= hi_len + 1;
        end else if (prev_r) begin
            last_w <= hi_len;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [4:0] a, input logic [31:0] d);
        @(negedge bclk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge bclk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input logic [4:0] a, output logic [31:0] d);
        @(negedge bclk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic set_ctrl(input logic [31:0] v, input logic [31:0] k);
        bw(5'h04, k);
        bw(5'h00, v);
    endtask

    task automatic wait_rise(input int maxc, output bit ok);
        int start = rise_cnt;
        ok = 1'b0;
        for (int i = 0; i < maxc && !ok; i++) begin
            @(posedge sclk);
            if (rise_cnt != start) ok = 1'b1;
        end
    endtask

    task automatic safe_wait(input int n);
        repeat (n) @(negedge sclk);
    endtask

    initial begin
        repeat (150000) @(posedge bclk);
        errors++;
        $display("FAIL watchdog expired before the run completed");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok;
        int base, t1, t2;
        brst = 1'b1; srst = 1'b1; halt = 1'b0;
        sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (5) @(posedge bclk);
        @(negedge bclk);
        brst = 1'b0; srst = 1'b0;

        // R1 reset state
        br(5'h00, d);  chk(d == 0, "R1 ctrl", d, 0);
        br(5'h08, d);  chk(d == 32'hFFFF_FFFF, "R1 period", d, 32'hFFFF_FFFF);
        chk(rst_o == 1'b0, "R1 rst_req", rst_o, 0);
        chk(irq_o == 1'b0, "R1 irq", irq_o, 0);

        // R5 key protection
        bw(5'h08, 32'd4); bw(5'h0C, 32'd3);
        set_ctrl(32'd1, BAD);
        br(5'h00, d);  chk(d == 0, "R5 wrong key", d, 0);
        bw(5'h04, KEY); bw(5'h08, 32'd4); bw(5'h00, 32'd1);
        br(5'h00, d);  chk(d == 0, "R5 write between key and ctrl", d, 0);
        bw(5'h04, KEY); bw(5'h04, BAD); bw(5'h00, 32'd1);
        br(5'h00, d);  chk(d == 0, "R5 relock by bad key", d, 0);
        base = rise_cnt;
        safe_wait(80);
        chk(rise_cnt == base, "R9 disabled no reset", rise_cnt - base, 0);
        set_ctrl(32'd1, KEY);
        br(5'h00, d);  chk(d == 1, "R5 correct key", d, 1);
        set_ctrl(32'd0, KEY);

        // R2 / R3 period and pulse sweep
        for (int p = 1; p <= 3; p++) begin
            for (int t = 2; t <= 4; t++) begin
                set_ctrl(32'd0, KEY);
                bw(5'h0C, p); bw(5'h08, t);
                set_ctrl(32'd1, KEY);
                wait_rise(200, ok);
                t1 = last_rise;
                wait_rise(200, ok);
                t2 = last_rise;
                chk(ok && (t2 - t1 == (t + 1) * (p + 1)), "R2 period", t2 - t1, (t + 1) * (p + 1));
                safe_wait(6);
                chk(last_w == 4, "R3 pulse width", last_w, 4);
            end
        end

        // R4 restarts hold off the reset
        set_ctrl(32'd0, KEY);
        bw(5'h0C, 32'd3); bw(5'h08, 32'd4);
        safe_wait(8);
        base = rise_cnt;
        set_ctrl(32'd1, KEY);
        for (int i = 0; i < 30; i++) begin
            bw(5'h10, 32'd1);
            repeat (5) @(negedge bclk);
        end
        chk(rise_cnt == base, "R4 restarts prevent reset", rise_cnt - base, 0);
        wait_rise(80, ok);
        chk(ok, "R4 reset after restarts stop", ok, 1);

        // R8 pause with halt
        set_ctrl(32'd5, KEY);
        wait_rise(200, ok);
        wait_rise(200, ok);
        t1 = last_rise;
        safe_wait(2); halt = 1'b1; safe_wait(7); halt = 1'b0;
        wait_rise(200, ok);
        t2 = last_rise;
        chk(ok && (t2 - t1 == 27), "R8 pause stretches interval", t2 - t1, 27);
        halt = 1'b1;
        safe_wait(4);
        base = rise_cnt;
        safe_wait(300);
        chk(rise_cnt == base, "R8 long pause holds", rise_cnt - base, 0);
        halt = 1'b0;
        set_ctrl(32'd1, KEY);
        wait_rise(200, ok);
        wait_rise(200, ok);
        t1 = last_rise;
        safe_wait(2); halt = 1'b1; safe_wait(7); halt = 1'b0;
        wait_rise(200, ok);
        t2 = last_rise;
        chk(ok && (t2 - t1 == 20), "R8 halt ignored without pause", t2 - t1, 20);

        // R6 / R7 / R10 debug mode
        set_ctrl(32'd0, KEY);
        bw(5'h14, 32'd1);
        safe_wait(10);
        base = rise_cnt;
        set_ctrl(32'd3, KEY);
        safe_wait(60);
        chk(rise_cnt == base, "R6 no reset in debug", rise_cnt - base, 0);
        chk(irq_o == 1'b1, "R6 interrupt raised", irq_o, 1);
        br(5'h1C, d);  chk(d[0] == 1'b1, "R10 status irq bit", d[0], 1);
        set_ctrl(32'd2, KEY);
        repeat (10) @(negedge bclk);
        chk(irq_o == 1'b1, "R7 irq held until clear", irq_o, 1);
        bw(5'h18, 32'd0);
        repeat (12) @(negedge bclk);
        chk(irq_o == 1'b0, "R7 clear", irq_o, 0);
        br(5'h1C, d);  chk(d == 0, "R10 status idle", d, 0);
        bw(5'h14, 32'd0);
        base = rise_cnt;
        set_ctrl(32'd3, KEY);
        safe_wait(60);
        chk(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
        chk(rise_cnt == base, "R6 no reset masked", rise_cnt - base, 0);
        set_ctrl(32'd0, KEY);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule